// File: doc/BRIEF.md
# Byte-Wide Access Bridge for 16-bit Registers

This block lets an 8-bit peripheral bus reach a small bank of 16-bit registers: one free-running counter and two data registers. Each register spans two byte addresses, and every transfer passes through one shared 8-bit holding latch. This keeps a 16-bit value consistent even though it moves one byte at a time.

Software must always touch the upper byte first. An upper-byte write only fills the holding latch. The lower-byte write that follows joins the latch with its own byte and updates the whole register on one clock edge. An upper-byte read returns the high half and, at the same edge, copies the low half into the latch. The following lower-byte read then returns that copy. A counter that is still counting therefore reads as one coherent snapshot. The hardware side sees both data registers and the live counter value.

Top module: `wide_reg_bridge`

## Requirements
- R1: A synchronous active-high reset clears the counter, both data registers, the holding latch and `rd_data` to zero. The counter stays at zero while reset is held, even with `cnt_en` high.
- R2: A write to an even address (upper byte) of a mapped register loads `wr_data` into the holding latch and leaves every register unchanged.
- R3: A write to an odd address (lower byte) stores {latch, `wr_data`} into the addressed register at that clock edge. On the counter, this load takes priority over counting.
- R4: A read of an even address of a mapped register updates `rd_data` at that edge with the register's bits [15:8]. At the same edge, the latch captures bits [7:0] of the same value.
- R5: A read of an odd address returns the latch contents, not the live low byte. After the counter has moved on, it still returns the byte captured by the upper read.
- R6: The counter increments by one, wrapping from 0xFFFF to 0x0000, on every clock with `cnt_en` high, no reset and no lower-byte write to it.
- R7: One latch serves all registers. An upper access to one register followed by a lower access to another register uses whatever the latch holds.
- R8: The address map is: 0/1 counter, 2/3 data A, 4/5 data B (even = upper byte). Addresses 6 and 7 are unmapped. Writes there change neither the registers nor the latch, and reads there return 0x00.
- R9: When `wr_en` and `rd_en` are high together, the write is performed and the read is dropped: neither `rd_data` nor the latch is changed by the read.
- R10: `rd_data` holds its value on cycles without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Counter advance enable |
| addr | input | ADDR_W (3) | Byte address |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_data | input | BUS_W (8) | Write byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rd_data | output | BUS_W (8) | Registered read byte |
| count | output | REG_W (16) | Live counter value |
| data_a | output | REG_W (16) | Data register A |
| data_b | output | REG_W (16) | Data register B |

## Verification
The counter, the registers, the latch and `rd_data` all change at the same rising edge that samples the strobe. The one exception is an upper-byte write, whose only effect is the latch; it shows up at the edge of the next lower access. The bench drives each strobe at the falling edge and samples 1 ns after the following rising edge. It enables the counter only in known windows, so the expected count is always a fixed number of edges away. The holding latch is observed only through later lower-byte reads and writes.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
   localparam int unsigned NUM_REGS = 3;
   typedef enum logic [1:0] {
      SEL_CNT  = 2'd0,
      SEL_A    = 2'd1,
      SEL_B    = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
   import wrb_pkg::*;
#(
   parameter int unsigned ADDR_W = 3
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic                wr_en,
   input  logic                rd_en,
   output reg_sel_e            sel,
   output logic                wr_hi,
   output logic [NUM_REGS-1:0] wr_lo_vec,
   output logic                rd_hi,
   output logic                rd_lo,
   output logic                rd_unmapped
);
   localparam int unsigned IDX_W = ADDR_W - 1;

   logic [IDX_W-1:0] idx;
   logic             mapped;
   logic             wr_act;
   logic             rd_act;

   assign idx    = addr[ADDR_W-1:1];
   assign mapped = (idx < IDX_W'(NUM_REGS));
   assign sel    = mapped ? reg_sel_e'(idx[1:0]) : SEL_NONE;

   // write wins over a simultaneous read
   assign wr_act      = wr_en & mapped;
   assign rd_act      = rd_en & ~wr_en & mapped;
   assign rd_unmapped = rd_en & ~wr_en & ~mapped;

   assign wr_hi = wr_act & ~addr[0];
   assign rd_hi = rd_act & ~addr[0];
   assign rd_lo = rd_act &  addr[0];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_wlo
      assign wr_lo_vec[i] = wr_act & addr[0] & (idx == IDX_W'(i));
   end
endmodule

// File: rtl/wrb_temp.sv
module wrb_temp #(
   parameter int unsigned BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_wr,
   input  logic [BUS_W-1:0] wr_byte,
   input  logic             load_rd,
   input  logic [BUS_W-1:0] rd_byte,
   output logic [BUS_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)          q <= '0;
      else if (load_wr) q <= wr_byte;
      else if (load_rd) q <= rd_byte;
   end
endmodule

// File: rtl/wrb_reg.sv
module wrb_reg #(
   parameter int unsigned REG_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   input  logic             load,
   input  logic [REG_W-1:0] load_val,
   output logic [REG_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= load_val;
      else if (inc)  q <= q + REG_W'(1);
   end
endmodule

// File: rtl/wrb_rdmux.sv
module wrb_rdmux
   import wrb_pkg::*;
#(
   parameter int unsigned BUS_W = 8,
   parameter int unsigned REG_W = 16
) (
   input  logic                           clk,
   input  logic                           rst,
   input  reg_sel_e                       sel,
   input  logic                           rd_hi,
   input  logic                           rd_lo,
   input  logic                           rd_unmapped,
   input  logic [NUM_REGS-1:0][REG_W-1:0] regs,
   input  logic [BUS_W-1:0]               tmp,
   output logic [BUS_W-1:0]               cap_lo,
   output logic [BUS_W-1:0]               rd_data
);
   logic [REG_W-1:0] word;
   logic [1:0]       sel_idx;

   assign sel_idx = sel;

   always_comb begin
      word = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (sel_idx == 2'(i)) word = regs[i];
      end
   end

   assign cap_lo = word[BUS_W-1:0];

   always_ff @(posedge clk) begin
      if (rst)              rd_data <= '0;
      else if (rd_hi)       rd_data <= word[REG_W-1:BUS_W];
      else if (rd_lo)       rd_data <= tmp;
      else if (rd_unmapped) rd_data <= '0;
   end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
   import wrb_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cnt_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic              rd_en,
   output logic [BUS_W-1:0]  rd_data,
   output logic [REG_W-1:0]  count,
   output logic [REG_W-1:0]  data_a,
   output logic [REG_W-1:0]  data_b
);
   if (REG_W != 2 * BUS_W) begin : g_bad_width
      $error("wide_reg_bridge: REG_W must be twice BUS_W");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("wide_reg_bridge: ADDR_W must cover three byte pairs");
   end

   reg_sel_e                       sel;
   logic                           wr_hi;
   logic [NUM_REGS-1:0]            wr_lo_vec;
   logic                           rd_hi;
   logic                           rd_lo;
   logic                           rd_unmapped;
   logic [BUS_W-1:0]               tmp_q;
   logic [BUS_W-1:0]               cap_lo;
   logic [NUM_REGS-1:0][REG_W-1:0] reg_q;
   logic [NUM_REGS-1:0]            inc;
   logic [REG_W-1:0]               join_val;

   assign join_val = {tmp_q, wr_data};

   wrb_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr        (addr),
      .wr_en       (wr_en),
      .rd_en       (rd_en),
      .sel         (sel),
      .wr_hi       (wr_hi),
      .wr_lo_vec   (wr_lo_vec),
      .rd_hi       (rd_hi),
      .rd_lo       (rd_lo),
      .rd_unmapped (rd_unmapped)
   );

   wrb_temp #(.BUS_W(BUS_W)) u_tmp (
      .clk     (clk),
      .rst     (rst),
      .load_wr (wr_hi),
      .wr_byte (wr_data),
      .load_rd (rd_hi),
      .rd_byte (cap_lo),
      .q       (tmp_q)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (i == int'(SEL_CNT)) begin : g_counter
         assign inc[i] = cnt_en;
      end else begin : g_data
         assign inc[i] = 1'b0;
      end
      wrb_reg #(.REG_W(REG_W)) u_reg (
         .clk      (clk),
         .rst      (rst),
         .inc      (inc[i]),
         .load     (wr_lo_vec[i]),
         .load_val (join_val),
         .q        (reg_q[i])
      );
   end

   wrb_rdmux #(.BUS_W(BUS_W), .REG_W(REG_W)) u_rd (
      .clk         (clk),
      .rst         (rst),
      .sel         (sel),
      .rd_hi       (rd_hi),
      .rd_lo       (rd_lo),
      .rd_unmapped (rd_unmapped),
      .regs        (reg_q),
      .tmp         (tmp_q),
      .cap_lo      (cap_lo),
      .rd_data     (rd_data)
   );

   assign count  = reg_q[0];
   assign data_a = reg_q[1];
   assign data_b = reg_q[2];
endmodule

// File: rtl/wrb_chk.sv
module wrb_chk #(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned REG_W  = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              cnt_en,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [BUS_W-1:0]  wr_data,
   input logic              rd_en,
   input logic [BUS_W-1:0]  rd_data,
   input logic [REG_W-1:0]  count,
   input logic [REG_W-1:0]  data_a,
   input logic [REG_W-1:0]  data_b,
   input logic [BUS_W-1:0]  tmp_q
);
   logic rd_ok;
   assign rd_ok = rd_en & ~wr_en;

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (count == '0 && data_a == '0 && data_b == '0 && rd_data == '0 && tmp_q == '0));

   // R2
   upper_write_no_reg_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !addr[0]) |=> ($stable(data_a) && $stable(data_b)));

   // R3
   lower_write_a_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(3)) |=> (data_a == {$past(tmp_q), $past(wr_data)}));

   // R4
   upper_read_a_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_ok && addr == ADDR_W'(2)) |=> (rd_data == $past(data_a[REG_W-1:BUS_W]) && tmp_q == $past(data_a[BUS_W-1:0])));

   // R5
   lower_read_latch_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_ok && addr[0] && addr < ADDR_W'(6)) |=> (rd_data == $past(tmp_q)));

   // R6
   counter_step_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && !(wr_en && addr == ADDR_W'(1))) |=> (count == $past(count) + REG_W'(1)));

   // R8
   unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_ok && addr >= ADDR_W'(6)) |=> (rd_data == '0));

   // R9
   collide_read_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && rd_en) |=> $stable(rd_data));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_en) |=> $stable(rd_data));
endmodule

bind wide_reg_bridge wrb_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .REG_W(REG_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .cnt_en  (cnt_en),
   .addr    (addr),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_en   (rd_en),
   .rd_data (rd_data),
   .count   (count),
   .data_a  (data_a),
   .data_b  (data_b),
   .tmp_q   (tmp_q)
);

// File: tb/sim_wide_reg_bridge.sv
`timescale 1ns/1ps
module sim_wide_reg_bridge;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cnt_en = 1'b0;
   logic [2:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_data;
   logic [15:0] count, data_a, data_b;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wide_reg_bridge u0 (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .addr(addr),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .count(count), .data_a(data_a), .data_b(data_b)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(posedge clk); #1;
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      cnt_en = 1'b1;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R1 count in reset", count, 16'h0000);
      @(negedge clk); rst = 1'b0; cnt_en = 1'b0;
      @(posedge clk); #1;
      check("R1 data_a", data_a, 16'h0000);
      check("R1 data_b", data_b, 16'h0000);
      check("R1 rd_data", {8'h00, rd_data}, 16'h0000);
      bus_read(3'd3, d);
      check("R1 latch cleared", {8'h00, d}, 16'h0000);
   endtask

   task automatic t_write;
      bus_write(3'd2, 8'hA5);
      check("R2 upper write leaves data_a", data_a, 16'h0000);
      check("R2 upper write leaves count", count, 16'h0000);
      bus_write(3'd3, 8'h3C);
      check("R3 lower write data_a", data_a, 16'hA53C);
      bus_write(3'd4, 8'h7E);
      bus_write(3'd5, 8'h81);
      check("R3 lower write data_b", data_b, 16'h7E81);
      check("R8 data_a untouched by B", data_a, 16'hA53C);
   endtask

   task automatic t_read;
      logic [7:0] d;
      bus_read(3'd2, d);
      check("R4 upper read A", {8'h00, d}, 16'h00A5);
      bus_read(3'd3, d);
      check("R5 lower read A", {8'h00, d}, 16'h003C);
      bus_read(3'd4, d);
      check("R4 upper read B", {8'h00, d}, 16'h007E);
      bus_read(3'd5, d);
      check("R5 lower read B", {8'h00, d}, 16'h0081);
   endtask

   task automatic t_counter;
      logic [7:0] d;
      bus_write(3'd0, 8'h12);
      bus_write(3'd1, 8'hFF);
      check("R3 counter load", count, 16'h12FF);
      @(negedge clk);
      cnt_en = 1'b1; addr = 3'd0; rd_en = 1'b1;
      @(posedge clk); #1;
      rd_en = 1'b0;
      check("R4 upper read counter", {8'h00, rd_data}, 16'h0012);
      check("R6 counter stepped", count, 16'h1300);
      repeat (3) @(posedge clk);
      bus_read(3'd1, d);
      cnt_en = 1'b0;
      check("R5 snapshot low byte", {8'h00, d}, 16'h00FF);
      check("R6 counter after 5 steps", count, 16'h1304);
      bus_write(3'd0, 8'hFF);
      bus_write(3'd1, 8'hFF);
      @(negedge clk); cnt_en = 1'b1;
      @(posedge clk); #1; cnt_en = 1'b0;
      check("R6 wrap", count, 16'h0000);
      @(negedge clk); cnt_en = 1'b1;
      bus_write(3'd0, 8'h40);
      bus_write(3'd1, 8'h00);
      cnt_en = 1'b0;
      check("R3 load beats count", count, 16'h4000);
      bus_read(3'd0, d);
      check("R4 upper read loaded counter", {8'h00, d}, 16'h0040);
   endtask

   task automatic t_shared;
      logic [7:0] d;
      bus_read(3'd4, d);
      bus_write(3'd3, 8'h11);
      check("R7 B low byte joins A write", data_a, 16'h8111);
      bus_write(3'd2, 8'h55);
      bus_read(3'd5, d);
      check("R7 A upper write read via B", {8'h00, d}, 16'h0055);
      check("R7 data_b untouched", data_b, 16'h7E81);
   endtask

   task automatic t_unmapped;
      logic [7:0] d;
      bus_write(3'd2, 8'h44);
      bus_write(3'd6, 8'h99);
      bus_write(3'd7, 8'h77);
      check("R8 unmapped write no reg change", data_a, 16'h8111);
      bus_write(3'd3, 8'h22);
      check("R8 unmapped write kept latch", data_a, 16'h4422);
      bus_read(3'd7, d);
      check("R8 unmapped read zero", {8'h00, d}, 16'h0000);
      check("R8 data_b unchanged", data_b, 16'h7E81);
   endtask

   task automatic t_collide;
      logic [7:0] d;
      bus_read(3'd2, d);
      check("R4 upper read A again", {8'h00, d}, 16'h0044);
      @(negedge clk);
      addr = 3'd5; wr_data = 8'h66; wr_en = 1'b1; rd_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0; rd_en = 1'b0;
      check("R9 write done", data_b, 16'h2266);
      check("R9 read dropped", {8'h00, rd_data}, 16'h0044);
      repeat (2) @(posedge clk);
      #1;
      check("R10 rd_data held", {8'h00, rd_data}, 16'h0044);
      bus_read(3'd3, d);
      check("R9 latch not overwritten", {8'h00, d}, 16'h0022);
   endtask

   initial begin
      t_reset();
      t_write();
      t_read();
      t_counter();
      t_shared();
      t_unmapped();
      t_collide();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule